// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block sits on the command side of a DDR SDRAM device model or a memory-side protocol checker. On every rising clock edge it samples chip select, the three active-low strobes (row strobe, column strobe, write enable), clock enable, a bank select and the address bus. It classifies the pattern as one of the basic commands and tracks, for each of the four banks, whether the bank is idle or has a row open and which row that is.

Results are registered. The decoded command, the target bank, the row or column, the open row of the addressed bank, the auto-precharge marker and an illegal-command flag all appear on the outputs after the same edge that sampled the pins. The per-bank open/idle state is visible as a vector, updated on that edge too.

Address bit 10 has two roles: on a read or write it requests a close of the bank after the access, and on a precharge it widens the close to every bank. A low clock enable freezes decoding for the following cycle. An auto-refresh pattern with clock enable falling enters self refresh, which lasts until clock enable is sampled high again.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: While cs_n_i is sampled high, the edge reports cmd_o = 0 (NOP) and changes no bank state, whatever the strobes carry.
- R2: cmd_o encodes NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5, SELF REFRESH=6, MODE REGISTER SET=7. It is decoded from {ras_n,cas_n,we_n} with cs_n low: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 refresh, 000 MODE REGISTER SET; 111 and 110 give NOP. A MODE REGISTER SET reports the full address on addr_o. All outputs update on the sampling edge.
- R3: An ACTIVE to an idle bank opens it and stores all 13 address bits as its row. It reports bank_o = ba_i and addr_o = the row.
- R4: A READ or WRITE reports the column on addr_o as the low address bits, zero-extended: 9 bits (A0..A8) when ORG_X16 = 1 and 10 bits when it is 0. row_o carries the open row of the addressed bank.
- R5: A legal READ or WRITE with address bit 10 high raises auto_pre_o and returns that bank to idle on the same edge.
- R6: A PRECHARGE with address bit 10 high idles every bank. With bit 10 low it idles only bank ba_i. addr_o reads 0 for a PRECHARGE.
- R7: A READ or WRITE to an idle bank, or an ACTIVE to an open bank, raises illegal_o for that cycle. Bank state and stored rows are unchanged, and row_o and auto_pre_o read 0.
- R8: When cke_i is sampled low on one edge, the command on the next edge is reported as NOP and has no effect.
- R9: A refresh pattern (001) sampled with cke_i low enters self refresh and reports SELF REFRESH. self_refresh_o then stays high until the first edge that samples cke_i high, where it drops.
- R10: A synchronous active-high rst_i idles all banks, clears stored rows and all outputs, and leaves decoding enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address bus |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Target bank of a bank command, else 0 |
| addr_o | output | 13 | Row, column or mode value |
| row_o | output | 13 | Open row of the target bank on a legal read/write |
| auto_pre_o | output | 1 | Read/write closes its bank |
| illegal_o | output | 1 | Command conflicts with bank state |
| self_refresh_o | output | 1 | Self refresh in progress |
| bank_open_o | output | 4 | Per-bank open flag |

## Verification
Several properties are checked on every cycle: a deselected edge reports NOP, a low clock enable forces a NOP two samples later, self refresh persists while clock enable stays low, an illegal command leaves the open vector untouched, and an auto-precharge report always coincides with its bank being idle. Some behaviour only the bench scenarios can show, because it depends on earlier history. This covers the row remembered by each bank being returned on later accesses, the column mask chosen by the organisation, precharge-all versus single-bank closing, and the exact entry and exit edges of self refresh. A behavioural model tracks that history and is compared on every clock.

// File: rtl/ddrdec_pkg.sv
package ddrdec_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_AREF = 3'd5,
        CMD_SREF = 3'd6,
        CMD_MRS  = 3'd7
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam int AP_BIT = 10;

    function automatic cmd_e decode_cmd(input pins_t p, input logic cke);
        cmd_e c;
        if (p.cs_n) begin
            c = CMD_NOP;
        end else begin
            unique case ({p.ras_n, p.cas_n, p.we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = cke ? CMD_AREF : CMD_SREF;
                3'b000:  c = CMD_MRS;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddrdec_cmd_decode.sv
module ddrdec_cmd_decode
    import ddrdec_pkg::*;
(
    input  pins_t pins_i,
    input  logic  cke_i,
    input  logic  en_i,
    output cmd_e  cmd_o
);
    always_comb begin
        if (en_i) cmd_o = decode_cmd(pins_i, cke_i);
        else      cmd_o = CMD_NOP;
    end
endmodule

// File: rtl/ddrdec_bank.sv
module ddrdec_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             open_en_i,
    input  logic             close_en_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (open_en_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (close_en_i) begin
            open_o <= 1'b0;
        end
    end

    p_open_close_excl_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(open_en_i && close_en_i))
        else $error("bank open and close requested together");
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddrdec_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int BANK_W   = 2,
    parameter bit ORG_X16  = 1'b1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   cke_i,
    input  logic                   cs_n_i,
    input  logic                   ras_n_i,
    input  logic                   cas_n_i,
    input  logic                   we_n_i,
    input  logic [BANK_W-1:0]      ba_i,
    input  logic [ROW_W-1:0]       addr_i,
    output logic [2:0]             cmd_o,
    output logic [BANK_W-1:0]      bank_o,
    output logic [ROW_W-1:0]       addr_o,
    output logic [ROW_W-1:0]       row_o,
    output logic                   auto_pre_o,
    output logic                   illegal_o,
    output logic                   self_refresh_o,
    output logic [(1<<BANK_W)-1:0] bank_open_o
);
    localparam int NB    = 1 << BANK_W;
    localparam int COL_W = ORG_X16 ? 9 : 10;

    pins_t            pins;
    cmd_e             cmd_now;
    logic             cke_q;
    logic             sref_q;
    logic [NB-1:0]    open_v;
    logic [NB-1:0]    act_en;
    logic [NB-1:0]    close_en;
    logic [ROW_W-1:0] rows [NB];
    logic             sel_open;
    logic             a10;
    logic             rw_now;
    logic             illegal_now;
    logic [ROW_W-1:0] col_ext;

    assign pins = '{cs_n: cs_n_i, ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};

    ddrdec_cmd_decode u_dec (
        .pins_i (pins),
        .cke_i  (cke_i),
        .en_i   (cke_q),
        .cmd_o  (cmd_now)
    );

    assign sel_open    = open_v[ba_i];
    assign a10         = addr_i[AP_BIT];
    assign rw_now      = is_access(cmd_now);
    assign illegal_now = ((cmd_now == CMD_ACT) && sel_open) || (rw_now && !sel_open);
    assign col_ext     = ROW_W'(addr_i[COL_W-1:0]);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign act_en[b]   = (cmd_now == CMD_ACT) && (ba_i == BANK_W'(b)) && !open_v[b];
        assign close_en[b] = ((cmd_now == CMD_PRE) && (a10 || (ba_i == BANK_W'(b)))) ||
                             (rw_now && (ba_i == BANK_W'(b)) && open_v[b] && a10);
        ddrdec_bank #(.ROW_W(ROW_W)) u_bank (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .open_en_i  (act_en[b]),
            .close_en_i (close_en[b]),
            .row_i      (addr_i),
            .open_o     (open_v[b]),
            .row_o      (rows[b])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cke_q      <= 1'b1;
            sref_q     <= 1'b0;
            cmd_o      <= CMD_NOP;
            bank_o     <= '0;
            addr_o     <= '0;
            row_o      <= '0;
            auto_pre_o <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            cke_q <= cke_i;
            if (cmd_now == CMD_SREF) sref_q <= 1'b1;
            else if (cke_i)          sref_q <= 1'b0;
            cmd_o      <= cmd_now;
            illegal_o  <= illegal_now;
            auto_pre_o <= rw_now && sel_open && a10;
            row_o      <= (rw_now && sel_open) ? rows[ba_i] : '0;
            unique case (cmd_now)
                CMD_ACT:        begin bank_o <= ba_i; addr_o <= addr_i;  end
                CMD_RD, CMD_WR: begin bank_o <= ba_i; addr_o <= col_ext; end
                CMD_PRE:        begin bank_o <= ba_i; addr_o <= '0;      end
                CMD_MRS:        begin bank_o <= '0;   addr_o <= addr_i;  end
                default:        begin bank_o <= '0;   addr_o <= '0;      end
            endcase
        end
    end

    assign self_refresh_o = sref_q;
    assign bank_open_o    = open_v;

    p_deselect_nop_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_i |=> (cmd_o == CMD_NOP))
        else $error("deselected edge not reported as NOP");

    p_autopre_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        auto_pre_o |-> !bank_open_o[bank_o])
        else $error("auto-precharged bank still open");

    p_illegal_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (bank_open_o == $past(bank_open_o)))
        else $error("illegal command changed bank state");

    p_illegal_kind_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (cmd_o == CMD_ACT || cmd_o == CMD_RD || cmd_o == CMD_WR))
        else $error("illegal flag on a non-bank command");

    p_cke_suspend_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !cke_i |=> ##1 (cmd_o == CMD_NOP))
        else $error("command decoded after clock enable low");

    p_sref_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (self_refresh_o && !cke_i) |=> self_refresh_o)
        else $error("self refresh left while clock enable low");
endmodule

// File: tb/ddr_cmd_decoder_test.sv
module ddr_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_i, cke_i, cs_n_i, ras_n_i, cas_n_i, we_n_i;
    logic [1:0]  ba_i;
    logic [12:0] addr_i;
    logic [2:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o, row_o;
    logic        auto_pre_o, illegal_o, self_refresh_o;
    logic [3:0]  bank_open_o;

    always #10 clk = ~clk;

    ddr_cmd_decoder uut (
        .clk_i(clk), .rst_i(rst_i), .cke_i(cke_i), .cs_n_i(cs_n_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .addr_i(addr_i), .cmd_o(cmd_o), .bank_o(bank_o),
        .addr_o(addr_o), .row_o(row_o), .auto_pre_o(auto_pre_o),
        .illegal_o(illegal_o), .self_refresh_o(self_refresh_o),
        .bank_open_o(bank_open_o)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   m_open [4];
    int   m_row [4];
    bit   m_ckep = 1'b1;
    bit   m_sref = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ras/cas/we patterns: 011 ACT, 101 RD, 100 WR, 010 PRE, 001 REF, 000 MRS, 111 NOP
    task automatic step(input bit r, input bit cs, input bit [2:0] rcw, input bit cke,
                        input bit [1:0] ba, input bit [12:0] a);
        int c, eb, ea, er, eap, eil, ov;
        string tag;
        rst_i = r; cs_n_i = cs; {ras_n_i, cas_n_i, we_n_i} = rcw;
        cke_i = cke; ba_i = ba; addr_i = a;
        @(posedge clk);
        c = 0; eb = 0; ea = 0; er = 0; eap = 0; eil = 0; tag = "R2";
        if (r) begin
            tag = "R10";
            for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
            m_ckep = 1; m_sref = 0;
        end else begin
            if (!m_ckep) tag = "R8";
            else if (cs) tag = "R1";
            else begin
                case (rcw)
                    3'b011: c = 1;
                    3'b101: c = 2;
                    3'b100: c = 3;
                    3'b010: c = 4;
                    3'b001: c = cke ? 5 : 6;
                    3'b000: c = 7;
                    default: c = 0;
                endcase
            end
            case (c)
                1: begin
                    eb = ba; ea = a; tag = "R3";
                    if (m_open[ba]) begin eil = 1; tag = "R7"; end
                    else begin m_open[ba] = 1; m_row[ba] = a; end
                end
                2, 3: begin
                    eb = ba; ea = a & 13'h1FF; tag = "R4";
                    if (!m_open[ba]) begin eil = 1; tag = "R7"; end
                    else begin
                        er = m_row[ba];
                        if (a[10]) begin eap = 1; m_open[ba] = 0; tag = "R5"; end
                    end
                end
                4: begin
                    eb = ba; tag = "R6";
                    if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
                    else m_open[ba] = 0;
                end
                6: tag = "R9";
                7: ea = a;
                default: ;
            endcase
            if (c == 6) m_sref = 1;
            else if (cke) m_sref = 0;
            if (!cke && m_sref) tag = "R9";
            m_ckep = cke;
        end
        ov = 0;
        for (int i = 0; i < 4; i++) ov |= int'(m_open[i]) << i;
        @(negedge clk);
        chk(tag, "cmd", int'(cmd_o), c);
        chk(tag, "bank", int'(bank_o), eb);
        chk(tag, "addr", int'(addr_o), ea);
        chk(tag, "row", int'(row_o), er);
        chk(tag, "auto_pre", int'(auto_pre_o), eap);
        chk(tag, "illegal", int'(illegal_o), eil);
        chk(tag, "self_refresh", int'(self_refresh_o), int'(m_sref));
        chk(tag, "bank_open", int'(bank_open_o), ov);
    endtask

    initial begin
        bit [31:0] lf;
        rst_i = 1; cke_i = 1; cs_n_i = 1; {ras_n_i, cas_n_i, we_n_i} = 3'b111;
        ba_i = 0; addr_i = 0;
        @(negedge clk);
        step(1, 0, 3'b011, 1, 0, 13'h0);          // R10 reset
        step(1, 0, 3'b011, 1, 0, 13'h0);
        step(0, 0, 3'b011, 1, 0, 13'h1ABC);       // R3 open bank 0
        step(0, 0, 3'b011, 1, 0, 13'h0123);       // R7 ACT to open bank
        step(0, 0, 3'b101, 1, 0, 13'h03FF);       // R4 column masked to 9 bits
        step(0, 0, 3'b101, 1, 1, 13'h0005);       // R7 read of idle bank
        step(0, 0, 3'b100, 1, 1, 13'h0005);       // R7 write of idle bank
        step(0, 0, 3'b011, 1, 1, 13'h0AAA);
        step(0, 0, 3'b011, 1, 2, 13'h1555);
        step(0, 0, 3'b011, 1, 3, 13'h1FFF);
        step(0, 0, 3'b100, 1, 2, 13'h0411);       // R5 write with auto-precharge
        step(0, 0, 3'b101, 1, 2, 13'h0011);       // R7 bank 2 now idle
        step(0, 0, 3'b010, 1, 3, 13'h0000);       // R6 single bank close
        step(0, 0, 3'b100, 1, 1, 13'h00F0);       // R4 write returns row of bank 1
        step(0, 0, 3'b010, 1, 0, 13'h0400);       // R6 precharge all
        step(0, 0, 3'b000, 1, 0, 13'h1033);       // R2 mode register set
        step(0, 1, 3'b011, 1, 0, 13'h0077);       // R1 deselected ACT pattern
        step(0, 0, 3'b110, 1, 0, 13'h0000);       // R2 unused pattern -> NOP
        step(0, 0, 3'b001, 1, 0, 13'h0000);       // R2 auto refresh
        step(0, 0, 3'b011, 0, 1, 13'h0222);       // ACT decoded, CKE low
        step(0, 0, 3'b011, 1, 2, 13'h0333);       // R8 suppressed
        step(0, 0, 3'b011, 1, 2, 13'h0333);       // decoded again
        step(0, 0, 3'b001, 0, 0, 13'h0000);       // R9 self refresh entry
        step(0, 0, 3'b101, 0, 1, 13'h0000);       // R9 held
        step(0, 0, 3'b010, 0, 0, 13'h0400);       // R9 held, ignored precharge
        step(0, 0, 3'b111, 1, 0, 13'h0000);       // R9 exit edge
        step(0, 0, 3'b101, 1, 1, 13'h0401);       // R5 read with auto-precharge
        lf = 32'hACE1_2357;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[31:27] == 0, lf[26:24] == 0, lf[23:21], lf[20:17] != 0,
                 lf[16:15], lf[12:0]);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule